// File: doc/BRIEF.md
# Translation fault syndrome reporter

This block is the last stage of an address translation pipeline. It receives one access per cycle: the effective address, whether the access is a load, a store or an instruction fetch, the access class of the instruction that issued it, the two relocation enables, the segment register selected for the address, and the result that the translation path computed. From these it produces the final real address and access rights. When the access cannot complete, it produces a one-cycle exception pulse that carries an exception class and an error code instead.

Three situations are settled here and not in the translation path. The first is relocation turned off, which gives a real-mode bypass. The second is a segment marked as direct-store, where special rules apply by access class and one reserved bus identifier forces a plain memory access. The third is the bit-exact fault syndrome. The block also keeps the two data-fault registers that exception software reads: the faulting data address and the data fault status. It does not vector the exception.

All results are registered. A request sampled on one rising edge produces its response, exception pulse and register updates on that same edge, so they are visible for the whole next cycle.

Top module: `xlat_fault_report`

## Requirements
- R1: Real mode applies when a fetch (kind 2) arrives with the fetch relocation enable low, or when a load (kind 0) or store (kind 1) arrives with the data relocation enable low. The real address then equals the effective address, the rights are read, write and execute (prot bits 0, 1 and 2 all set), and no exception is raised, whatever the translation status.
- R2: Every accepted request gives `rsp_valid` exactly one cycle later. In a translated, non-direct-store access with translation status 0 (granted), the translation path's address and rights appear unchanged. On any fault the real address and rights read zero.
- R3: In a direct-store segment (segment bit 31 set) whose bus-ID field, segment bits 28:20, equals 0x07F, the real address is segment bits 3:0 above effective bits 27:0. The rights are full and there is no exception, for every access kind and class.
- R4: Instruction faults raise exception class 1 with error code 0x40000000 for translation status 1 (no mapping), 0x08000000 for status 2 (protection), and 0x10000000 for status 3 (no-execute) or for a fetch from a direct-store segment that is not forced.
- R5: A data miss (status 1) raises class 2 with a status register value of 0x40000000 for a load and 0x42000000 for a store. A data protection violation (status 2) gives 0x08000000 for a load and 0x0A000000 for a store.
- R6: In a non-forced direct-store segment, a reservation access (class 2) raises class 2 with status 0x04000000 for a load and 0x06000000 for a store. An external-control access (class 4) gives 0x04100000 for a load and 0x06100000 for a store.
- R7: In a non-forced direct-store segment, a floating access (class 1) raises the alignment exception class 3, and an access class of 5, 6 or 7 raises the invalid-program class 4. Both latch the effective address into the data-address register and leave the data-status register unchanged.
- R8: In a non-forced direct-store segment, a cache-control data access (class 3) completes with real address equal to the effective address, rights zero and no exception.
- R9: In a non-forced direct-store segment, an integer access (class 0) uses a key that is segment bit 29 in user mode and segment bit 30 in supervisor mode. A load completes when the key is 0, and a store completes when the key is 1. Both complete with the effective address and read/write rights (prot 3'b011). Any other case is a data protection violation coded as in R5.
- R10: Reset clears both data-fault registers. They change only in the cycle of an exception pulse. Every data-side fault writes the effective address into the data-address register, and instruction faults change neither register.
- R11: In a direct-store segment under relocation, the translation status and the translation address have no effect on the result.
- R12: A no-execute translation status (3) on a load or store is reported as a data protection violation, with the R5 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| eff_addr | input | ADDR_W | Effective address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_class | input | 3 | 0 integer, 1 floating, 2 reservation, 3 cache-control, 4 external; 5-7 unexpected |
| user_mode | input | 1 | Access is made at user privilege |
| relo_fetch_en | input | 1 | Instruction relocation enable |
| relo_data_en | input | 1 | Data relocation enable |
| seg_word | input | SEG_W | Segment register for the address (bit 31 direct-store, 30 supervisor key, 29 user key) |
| xlat_status | input | 2 | 0 granted, 1 no mapping, 2 protection, 3 no-execute |
| xlat_addr | input | ADDR_W | Real address from the translation path |
| xlat_prot | input | 3 | Rights from the translation path (bit 0 read, 1 write, 2 execute) |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| real_addr | output | ADDR_W | Final real address |
| real_prot | output | 3 | Final rights |
| exc_pulse | output | 1 | One-cycle exception indication |
| exc_class | output | 3 | 0 none, 1 instruction fault, 2 data fault, 3 alignment, 4 invalid program |
| exc_code | output | STAT_W | Error code of an instruction fault, zero otherwise |
| data_addr_q | output | ADDR_W | Latched faulting data address |
| data_stat_q | output | STAT_W | Latched data fault status |

## Verification
On every cycle the assertions check the following. A response follows each request by exactly one cycle. The exception pulse and a non-zero exception class always appear together. Real-mode accesses pass through without a fault. The fault registers hold outside an exception pulse and stay untouched on instruction faults. Every data-side fault captures the address. Alignment and invalid-program faults leave the status register alone. Only the bench scenarios can show the exact codes for each cause and direction, the forced bus-ID address splice, the key polarity of direct-store integer accesses, the cache-control no-op, and that the translation result is ignored in direct-store segments.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

   typedef enum logic [1:0] {
      AK_LOAD  = 2'd0,
      AK_STORE = 2'd1,
      AK_FETCH = 2'd2,
      AK_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      AC_INT   = 3'd0,
      AC_FLOAT = 3'd1,
      AC_RESV  = 3'd2,
      AC_CACHE = 3'd3,
      AC_EXT   = 3'd4,
      AC_BAD5  = 3'd5,
      AC_BAD6  = 3'd6,
      AC_BAD7  = 3'd7
   } acc_class_e;

   typedef enum logic [1:0] {
      XS_OK     = 2'd0,
      XS_MISS   = 2'd1,
      XS_PROT   = 2'd2,
      XS_NOEXEC = 2'd3
   } xlat_st_e;

   typedef enum logic [3:0] {
      FC_NONE,
      FC_MISS,
      FC_PROT,
      FC_NOEXEC,
      FC_DS_FETCH,
      FC_DS_FLOAT,
      FC_DS_RESV,
      FC_DS_EXT,
      FC_DS_BADCLASS
   } cause_e;

   typedef enum logic [2:0] {
      EX_NONE    = 3'd0,
      EX_FETCH   = 3'd1,
      EX_DATA    = 3'd2,
      EX_ALIGN   = 3'd3,
      EX_PROGRAM = 3'd4
   } exc_class_e;

   // syndrome values (32-bit status word)
   localparam logic [31:0] CODE_NOMAP  = 32'h4000_0000;
   localparam logic [31:0] CODE_PROT   = 32'h0800_0000;
   localparam logic [31:0] CODE_NOEXEC = 32'h1000_0000;
   localparam logic [31:0] STAT_STORE  = 32'h0200_0000;
   localparam logic [31:0] STAT_RESV   = 32'h0400_0000;
   localparam logic [31:0] STAT_EXT    = 32'h0410_0000;

   // segment word bit positions
   localparam int SEG_DS_BIT      = 31;
   localparam int SEG_KEY_SUP_BIT = 30;
   localparam int SEG_KEY_USR_BIT = 29;

   // rights: bit 0 read, bit 1 write, bit 2 execute
   localparam logic [2:0] PROT_ALL  = 3'b111;
   localparam logic [2:0] PROT_RW   = 3'b011;
   localparam logic [2:0] PROT_NONE = 3'b000;

endpackage

// File: rtl/xfr_dstore.sv
module xfr_dstore
   import xfr_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SEG_W        = 32,
   parameter int BUS_ID_W     = 9,
   parameter int BUS_ID_LSB   = 20,
   parameter logic [BUS_ID_W-1:0] FORCED_BUS_ID = 9'h07F,
   parameter bit HAS_FORCED_IO = 1'b1,
   parameter int FORCED_HI_W  = 4
) (
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [SEG_W-1:0]  seg_word,
   input  logic              is_fetch,
   input  logic              is_store,
   input  logic              user_mode,
   input  acc_class_e        acc_class,
   output cause_e            ds_cause,
   output logic [ADDR_W-1:0] ds_addr,
   output logic [2:0]        ds_prot
);

   localparam int LOW_W = ADDR_W - FORCED_HI_W;

   logic              forced_hit;
   logic [ADDR_W-1:0] forced_addr;
   logic              key;
   logic              unused_seg;

   assign unused_seg = ^seg_word;

   generate
      if (HAS_FORCED_IO) begin : g_forced
         assign forced_hit  = (seg_word[BUS_ID_LSB +: BUS_ID_W] == FORCED_BUS_ID);
         assign forced_addr = {seg_word[FORCED_HI_W-1:0], eff_addr[LOW_W-1:0]};
      end else begin : g_no_forced
         assign forced_hit  = 1'b0;
         assign forced_addr = '0;
      end
   endgenerate

   assign key = user_mode ? seg_word[SEG_KEY_USR_BIT] : seg_word[SEG_KEY_SUP_BIT];

   always_comb begin
      ds_cause = FC_NONE;
      ds_addr  = '0;
      ds_prot  = PROT_NONE;
      if (forced_hit) begin
         ds_addr = forced_addr;
         ds_prot = PROT_ALL;
      end else if (is_fetch) begin
         ds_cause = FC_DS_FETCH;
      end else begin
         case (acc_class)
            AC_INT: begin
               // loads need a clear key, stores a set key
               if (is_store == key) begin
                  ds_addr = eff_addr;
                  ds_prot = PROT_RW;
               end else begin
                  ds_cause = FC_PROT;
               end
            end
            AC_FLOAT: ds_cause = FC_DS_FLOAT;
            AC_RESV:  ds_cause = FC_DS_RESV;
            AC_CACHE: ds_addr  = eff_addr;
            AC_EXT:   ds_cause = FC_DS_EXT;
            default:  ds_cause = FC_DS_BADCLASS;
         endcase
      end
   end

endmodule

// File: rtl/xfr_encode.sv
module xfr_encode
   import xfr_pkg::*;
#(
   parameter int STAT_W = 32
) (
   input  cause_e            cause,
   input  logic              is_fetch,
   input  logic              is_store,
   output exc_class_e        enc_class,
   output logic [STAT_W-1:0] enc_code,
   output logic [STAT_W-1:0] enc_stat,
   output logic              stat_we,
   output logic              addr_we
);

   logic [STAT_W-1:0] dir_bit;

   assign dir_bit = is_store ? STAT_STORE : '0;

   always_comb begin
      enc_class = EX_NONE;
      enc_code  = '0;
      enc_stat  = '0;
      stat_we   = 1'b0;
      addr_we   = 1'b0;
      if (cause != FC_NONE) begin
         if (is_fetch) begin
            enc_class = EX_FETCH;
            case (cause)
               FC_MISS: enc_code = CODE_NOMAP;
               FC_PROT: enc_code = CODE_PROT;
               default: enc_code = CODE_NOEXEC;
            endcase
         end else begin
            addr_we = 1'b1;
            case (cause)
               FC_MISS: begin
                  enc_class = EX_DATA;
                  enc_stat  = CODE_NOMAP | dir_bit;
                  stat_we   = 1'b1;
               end
               FC_PROT, FC_NOEXEC: begin
                  enc_class = EX_DATA;
                  enc_stat  = CODE_PROT | dir_bit;
                  stat_we   = 1'b1;
               end
               FC_DS_RESV: begin
                  enc_class = EX_DATA;
                  enc_stat  = STAT_RESV | dir_bit;
                  stat_we   = 1'b1;
               end
               FC_DS_EXT: begin
                  enc_class = EX_DATA;
                  enc_stat  = STAT_EXT | dir_bit;
                  stat_we   = 1'b1;
               end
               FC_DS_FLOAT: enc_class = EX_ALIGN;
               default:     enc_class = EX_PROGRAM;
            endcase
         end
      end
   end

endmodule

// File: rtl/xfr_syndrome.sv
module xfr_syndrome #(
   parameter int ADDR_W = 32,
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic              stat_we,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [STAT_W-1:0] stat_in,
   output logic [ADDR_W-1:0] data_addr_q,
   output logic [STAT_W-1:0] data_stat_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_addr_q <= '0;
         data_stat_q <= '0;
      end else begin
         if (addr_we) data_addr_q <= addr_in;
         if (stat_we) data_stat_q <= stat_in;
      end
   end

endmodule

// File: rtl/xlat_fault_report.sv
module xlat_fault_report
   import xfr_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SEG_W        = 32,
   parameter int STAT_W       = 32,
   parameter int BUS_ID_W     = 9,
   parameter int BUS_ID_LSB   = 20,
   parameter logic [BUS_ID_W-1:0] FORCED_BUS_ID = 9'h07F,
   parameter bit HAS_FORCED_IO = 1'b1,
   parameter int FORCED_HI_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [1:0]        acc_kind,
   input  logic [2:0]        acc_class,
   input  logic              user_mode,
   input  logic              relo_fetch_en,
   input  logic              relo_data_en,
   input  logic [SEG_W-1:0]  seg_word,
   input  logic [1:0]        xlat_status,
   input  logic [ADDR_W-1:0] xlat_addr,
   input  logic [2:0]        xlat_prot,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] real_addr,
   output logic [2:0]        real_prot,
   output logic              exc_pulse,
   output logic [2:0]        exc_class,
   output logic [STAT_W-1:0] exc_code,
   output logic [ADDR_W-1:0] data_addr_q,
   output logic [STAT_W-1:0] data_stat_q
);

   localparam int BUS_ID_MSB = BUS_ID_LSB + BUS_ID_W - 1;

   initial begin
      if (ADDR_W != 32 || STAT_W != 32 || SEG_W != 32)
         $fatal(1, "xlat_fault_report: address, segment and status words must be 32 bits");
      if (BUS_ID_MSB >= SEG_W || FORCED_HI_W >= ADDR_W)
         $fatal(1, "xlat_fault_report: bus-ID field or forced splice out of range");
   end

   acc_kind_e         kind;
   logic              is_fetch;
   logic              is_store;
   logic              real_mode;

   cause_e            ds_cause;
   logic [ADDR_W-1:0] ds_addr;
   logic [2:0]        ds_prot;

   cause_e            n_cause;
   logic [ADDR_W-1:0] n_addr;
   logic [2:0]        n_prot;

   exc_class_e        enc_class;
   logic [STAT_W-1:0] enc_code;
   logic [STAT_W-1:0] enc_stat;
   logic              enc_stat_we;
   logic              enc_addr_we;

   assign kind      = acc_kind_e'(acc_kind);
   assign is_fetch  = (kind == AK_FETCH);
   assign is_store  = (kind == AK_STORE);
   assign real_mode = is_fetch ? !relo_fetch_en : !relo_data_en;

   xfr_dstore #(
      .ADDR_W       (ADDR_W),
      .SEG_W        (SEG_W),
      .BUS_ID_W     (BUS_ID_W),
      .BUS_ID_LSB   (BUS_ID_LSB),
      .FORCED_BUS_ID(FORCED_BUS_ID),
      .HAS_FORCED_IO(HAS_FORCED_IO),
      .FORCED_HI_W  (FORCED_HI_W)
   ) u_dstore (
      .eff_addr (eff_addr),
      .seg_word (seg_word),
      .is_fetch (is_fetch),
      .is_store (is_store),
      .user_mode(user_mode),
      .acc_class(acc_class_e'(acc_class)),
      .ds_cause (ds_cause),
      .ds_addr  (ds_addr),
      .ds_prot  (ds_prot)
   );

   always_comb begin
      n_cause = FC_NONE;
      n_addr  = '0;
      n_prot  = PROT_NONE;
      if (real_mode) begin
         n_addr = eff_addr;
         n_prot = PROT_ALL;
      end else if (seg_word[SEG_DS_BIT]) begin
         n_cause = ds_cause;
         n_addr  = ds_addr;
         n_prot  = ds_prot;
      end else begin
         case (xlat_st_e'(xlat_status))
            XS_OK: begin
               n_addr = xlat_addr;
               n_prot = xlat_prot;
            end
            XS_MISS: n_cause = FC_MISS;
            XS_PROT: n_cause = FC_PROT;
            default: n_cause = FC_NOEXEC;
         endcase
      end
   end

   xfr_encode #(
      .STAT_W(STAT_W)
   ) u_encode (
      .cause    (n_cause),
      .is_fetch (is_fetch),
      .is_store (is_store),
      .enc_class(enc_class),
      .enc_code (enc_code),
      .enc_stat (enc_stat),
      .stat_we  (enc_stat_we),
      .addr_we  (enc_addr_we)
   );

   xfr_syndrome #(
      .ADDR_W(ADDR_W),
      .STAT_W(STAT_W)
   ) u_syndrome (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_we    (req_valid & enc_addr_we),
      .stat_we    (req_valid & enc_stat_we),
      .addr_in    (eff_addr),
      .stat_in    (enc_stat),
      .data_addr_q(data_addr_q),
      .data_stat_q(data_stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         exc_pulse <= 1'b0;
         exc_class <= EX_NONE;
         exc_code  <= '0;
         real_addr <= '0;
         real_prot <= PROT_NONE;
      end else begin
         rsp_valid <= req_valid;
         exc_pulse <= req_valid && (n_cause != FC_NONE);
         exc_class <= req_valid ? enc_class : EX_NONE;
         exc_code  <= req_valid ? enc_code : '0;
         if (req_valid) begin
            real_addr <= n_addr;
            real_prot <= n_prot;
         end
      end
   end

endmodule

// File: rtl/xfr_checker.sv
module xfr_checker #(
   parameter int ADDR_W = 32,
   parameter int STAT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] eff_addr,
   input logic [1:0]        acc_kind,
   input logic              relo_fetch_en,
   input logic              relo_data_en,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] real_addr,
   input logic [2:0]        real_prot,
   input logic              exc_pulse,
   input logic [2:0]        exc_class,
   input logic [ADDR_W-1:0] data_addr_q,
   input logic [STAT_W-1:0] data_stat_q
);

   logic real_cond;
   assign real_cond = (acc_kind == 2'd2) ? !relo_fetch_en : !relo_data_en;

   p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   p_pulse_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse == (exc_class != 3'd0));

   p_real_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(real_cond)) |->
         (!exc_pulse && real_addr == $past(eff_addr) && real_prot == 3'b111));

   p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_pulse |-> ($stable(data_addr_q) && $stable(data_stat_q)));

   p_fetch_keeps_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_pulse && exc_class == 3'd1) |->
         ($stable(data_addr_q) && $stable(data_stat_q)));

   p_data_addr_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_pulse && exc_class != 3'd1) |-> data_addr_q == $past(eff_addr));

   p_align_prog_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_pulse && (exc_class == 3'd3 || exc_class == 3'd4)) |-> $stable(data_stat_q));

endmodule

bind xlat_fault_report xfr_checker #(
   .ADDR_W(ADDR_W),
   .STAT_W(STAT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .eff_addr     (eff_addr),
   .acc_kind     (acc_kind),
   .relo_fetch_en(relo_fetch_en),
   .relo_data_en (relo_data_en),
   .rsp_valid    (rsp_valid),
   .real_addr    (real_addr),
   .real_prot    (real_prot),
   .exc_pulse    (exc_pulse),
   .exc_class    (exc_class),
   .data_addr_q  (data_addr_q),
   .data_stat_q  (data_stat_q)
);

// File: tb/sim_xlat_fault_report.sv
`timescale 1ns/1ps
module sim_xlat_fault_report;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] eff_addr = '0;
   logic [1:0]  acc_kind = '0;
   logic [2:0]  acc_class = '0;
   logic        user_mode = 1'b0;
   logic        relo_fetch_en = 1'b0;
   logic        relo_data_en = 1'b0;
   logic [31:0] seg_word = '0;
   logic [1:0]  xlat_status = '0;
   logic [31:0] xlat_addr = '0;
   logic [2:0]  xlat_prot = '0;
   logic        rsp_valid;
   logic [31:0] real_addr;
   logic [2:0]  real_prot;
   logic        exc_pulse;
   logic [2:0]  exc_class;
   logic [31:0] exc_code;
   logic [31:0] data_addr_q;
   logic [31:0] data_stat_q;

   always #10 clk = ~clk;   // 50 MHz

   xlat_fault_report u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .eff_addr(eff_addr),
      .acc_kind(acc_kind), .acc_class(acc_class), .user_mode(user_mode),
      .relo_fetch_en(relo_fetch_en), .relo_data_en(relo_data_en),
      .seg_word(seg_word), .xlat_status(xlat_status), .xlat_addr(xlat_addr),
      .xlat_prot(xlat_prot), .rsp_valid(rsp_valid), .real_addr(real_addr),
      .real_prot(real_prot), .exc_pulse(exc_pulse), .exc_class(exc_class),
      .exc_code(exc_code), .data_addr_q(data_addr_q), .data_stat_q(data_stat_q)
   );

   typedef struct {
      logic [31:0] addr;
      logic [2:0]  prot;
      logic [2:0]  cls;
      logic [31:0] code;
      logic [31:0] dar;
      logic [31:0] dsr;
      string       tag;
   } exp_t;

   exp_t        sbq[$];
   int          n_checks = 0;
   int          n_errors = 0;
   bit          reported = 1'b0;
   logic [31:0] m_dar = '0;
   logic [31:0] m_dsr = '0;

   localparam logic [31:0] SEG_PAGE   = 32'h0000_0123;
   localparam logic [31:0] SEG_FORCED = 32'h87F0_0005;
   localparam logic [31:0] SEG_DS     = 32'h8010_0000;
   localparam logic [31:0] SEG_DS_KS  = 32'hC010_0000;
   localparam logic [31:0] SEG_DS_KP  = 32'hA010_0000;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      end
   endtask

   // driver: computes the expectation from the requirements and applies stimulus
   task automatic send(input logic [1:0] kind, input logic [2:0] cls, input logic usr,
                       input logic fe, input logic de, input logic [31:0] seg,
                       input logic [1:0] st, input logic [31:0] ea,
                       input logic [31:0] xa, input logic [2:0] xp, input string tag);
      exp_t        e;
      bit          fetch, store, realm, dfault;
      logic [31:0] dbase;
      logic        key;
      fetch  = (kind == 2'd2);
      store  = (kind == 2'd1);
      realm  = fetch ? !fe : !de;
      dfault = 1'b0;
      dbase  = '0;
      e.addr = '0; e.prot = '0; e.cls = '0; e.code = '0; e.tag = tag;
      if (realm) begin
         e.addr = ea; e.prot = 3'b111;
      end else if (seg[31]) begin
         if (seg[28:20] == 9'h07F) begin
            e.addr = {seg[3:0], ea[27:0]}; e.prot = 3'b111;
         end else if (fetch) begin
            e.cls = 3'd1; e.code = 32'h1000_0000;
         end else begin
            key = usr ? seg[29] : seg[30];
            case (cls)
               3'd0: if (store == key) begin e.addr = ea; e.prot = 3'b011; end
                     else begin dfault = 1'b1; dbase = 32'h0800_0000; end
               3'd1: begin e.cls = 3'd3; m_dar = ea; end
               3'd2: begin dfault = 1'b1; dbase = 32'h0400_0000; end
               3'd3: e.addr = ea;
               3'd4: begin dfault = 1'b1; dbase = 32'h0410_0000; end
               default: begin e.cls = 3'd4; m_dar = ea; end
            endcase
         end
      end else begin
         case (st)
            2'd0: begin e.addr = xa; e.prot = xp; end
            2'd1: if (fetch) begin e.cls = 3'd1; e.code = 32'h4000_0000; end
                  else begin dfault = 1'b1; dbase = 32'h4000_0000; end
            2'd2: if (fetch) begin e.cls = 3'd1; e.code = 32'h0800_0000; end
                  else begin dfault = 1'b1; dbase = 32'h0800_0000; end
            default: if (fetch) begin e.cls = 3'd1; e.code = 32'h1000_0000; end
                     else begin dfault = 1'b1; dbase = 32'h0800_0000; end
         endcase
      end
      if (dfault) begin
         e.cls = 3'd2;
         m_dar = ea;
         m_dsr = dbase | (store ? 32'h0200_0000 : 32'h0);
      end
      e.dar = m_dar;
      e.dsr = m_dsr;
      @(negedge clk);
      acc_kind = kind; acc_class = cls; user_mode = usr;
      relo_fetch_en = fe; relo_data_en = de; seg_word = seg;
      xlat_status = st; eff_addr = ea; xlat_addr = xa; xlat_prot = xp;
      req_valid = 1'b1;
      sbq.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: pops and compares each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R2", "unexpected response", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(real_addr == e.addr, e.tag, "real_addr", real_addr, e.addr);
            chk(real_prot == e.prot, e.tag, "real_prot", {29'd0, real_prot}, {29'd0, e.prot});
            chk(exc_pulse == (e.cls != 3'd0), e.tag, "exc_pulse", {31'd0, exc_pulse},
                {31'd0, (e.cls != 3'd0)});
            chk(exc_class == e.cls, e.tag, "exc_class", {29'd0, exc_class}, {29'd0, e.cls});
            chk(exc_code == e.code, e.tag, "exc_code", exc_code, e.code);
            chk(data_addr_q == e.dar, e.tag, "data_addr_q", data_addr_q, e.dar);
            chk(data_stat_q == e.dsr, e.tag, "data_stat_q", data_stat_q, e.dsr);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      chk(1'b0, "R2", "watchdog expired", 32'd0, 32'd1);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk(exc_pulse == 1'b0, "R10", "reset exc_pulse", {31'd0, exc_pulse}, 32'd0);
      chk(data_addr_q == '0, "R10", "reset data_addr_q", data_addr_q, 32'd0);
      chk(data_stat_q == '0, "R10", "reset data_stat_q", data_stat_q, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: real mode ignores translation status
      send(2'd2, 3'd0, 1'b0, 1'b0, 1'b1, SEG_PAGE, 2'd1, 32'h1234_5678, 32'h0, 3'b000, "R1");
      send(2'd1, 3'd0, 1'b0, 1'b1, 1'b0, SEG_DS,   2'd2, 32'h2222_0004, 32'h0, 3'b000, "R1");
      // R2: granted translation
      send(2'd0, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd0, 32'h3000_0010, 32'h00AB_C010, 3'b101, "R2");
      // R4: instruction faults
      send(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd1, 32'h4000_0100, 32'h0, 3'b000, "R4");
      send(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd2, 32'h4000_0200, 32'h0, 3'b000, "R4");
      send(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd3, 32'h4000_0300, 32'h0, 3'b000, "R4");
      // R5: data miss / protection, both directions
      send(2'd0, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd1, 32'h5000_0004, 32'h0, 3'b000, "R5");
      send(2'd1, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd1, 32'h5000_0008, 32'h0, 3'b000, "R5");
      send(2'd0, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd2, 32'h5000_000C, 32'h0, 3'b000, "R5");
      send(2'd1, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd2, 32'h5000_0010, 32'h0, 3'b000, "R5");
      // R12: data no-execute reported as protection
      send(2'd0, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd3, 32'h5100_0000, 32'h0, 3'b000, "R12");
      send(2'd1, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd3, 32'h5100_0004, 32'h0, 3'b000, "R12");
      // R3: forced bus-ID
      send(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, SEG_FORCED, 2'd1, 32'hF123_4567, 32'h0, 3'b000, "R3");
      send(2'd1, 3'd1, 1'b1, 1'b1, 1'b1, SEG_FORCED, 2'd0, 32'h0ABC_DEF0, 32'h0, 3'b000, "R3");
      // R4 / R10: direct-store fetch leaves the data registers alone
      send(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h6000_0040, 32'h0, 3'b000, "R4");
      // R6: reservation and external-control
      send(2'd0, 3'd2, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h7000_0000, 32'h0, 3'b000, "R6");
      send(2'd1, 3'd2, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h7000_0004, 32'h0, 3'b000, "R6");
      send(2'd0, 3'd4, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h7000_0008, 32'h0, 3'b000, "R6");
      send(2'd1, 3'd4, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h7000_000C, 32'h0, 3'b000, "R6");
      // R7: alignment and invalid program; R11: translation result ignored
      send(2'd0, 3'd1, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h7100_0000, 32'h1111_0000, 3'b111, "R7");
      send(2'd1, 3'd6, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd0, 32'h7200_0000, 32'h1111_0000, 3'b111, "R7");
      // R8 / R11: cache-control no-op with a miss reported by translation
      send(2'd0, 3'd3, 1'b0, 1'b1, 1'b1, SEG_DS, 2'd1, 32'h7300_0020, 32'h0, 3'b000, "R8");
      send(2'd1, 3'd3, 1'b1, 1'b1, 1'b1, SEG_DS, 2'd2, 32'h7300_0024, 32'h0, 3'b000, "R11");
      // R9: integer key polarity and key selection
      send(2'd0, 3'd0, 1'b0, 1'b1, 1'b1, SEG_DS,    2'd0, 32'h7400_0000, 32'h0, 3'b000, "R9");
      send(2'd1, 3'd0, 1'b0, 1'b1, 1'b1, SEG_DS,    2'd0, 32'h7400_0004, 32'h0, 3'b000, "R9");
      send(2'd1, 3'd0, 1'b0, 1'b1, 1'b1, SEG_DS_KS, 2'd0, 32'h7400_0008, 32'h0, 3'b000, "R9");
      send(2'd0, 3'd0, 1'b0, 1'b1, 1'b1, SEG_DS_KS, 2'd0, 32'h7400_000C, 32'h0, 3'b000, "R9");
      send(2'd1, 3'd0, 1'b1, 1'b1, 1'b1, SEG_DS_KP, 2'd0, 32'h7400_0010, 32'h0, 3'b000, "R9");
      send(2'd0, 3'd0, 1'b1, 1'b1, 1'b1, SEG_DS_KP, 2'd0, 32'h7400_0014, 32'h0, 3'b000, "R9");
      send(2'd0, 3'd0, 1'b1, 1'b1, 1'b1, SEG_DS_KS, 2'd0, 32'h7400_0018, 32'h0, 3'b000, "R9");
      // R10: a later instruction fault keeps the last data syndrome
      send(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, SEG_PAGE, 2'd1, 32'h7500_0000, 32'h0, 3'b000, "R10");

      repeat (3) @(negedge clk);
      chk(sbq.size() == 0, "R2", "responses outstanding", sbq.size(), 32'd0);
      summary();
      $finish;
   end

endmodule